// File: doc/BRIEF.md
# Clock Output Power-Down Sequencer

This block sits beside the synthesizer of a clock generator and decides when its output clocks may toggle. A single input pin does two jobs: after reset it is a power-good qualifier, and once it has been seen high it becomes an active-low power-down request. The block drives the enables of the crystal oscillator and the synthesizer VCO, watches a PLL lock indication, and owns one gate cell per output clock: single-ended outputs and differential pairs.

A power-down request is resynchronised to the reference clock and only acted on after two consecutive low samples. Each output is then stopped at its own next falling edge, so it ends low with no runt pulse, and a differential pair ends with both legs low. Once every gate reports itself idle the oscillator and VCO are switched off. Releasing the pin turns them back on; outputs return only after lock is reported and a set number of cycles of each output's own clock have passed, and each one resumes during a low phase. If the pin drops again within a start-up window after first power-good, the block goes straight to the off state without ever opening an output.

Top module: `clkpd_seq`

## Requirements
- R1: After reset the status is 0 (waiting for power-good), every output leg is low, and the oscillator and VCO enables are high.
- R2: While waiting for power-good a low pin is not a power-down: status stays 0 and outputs stay low; a high pin moves status to 4 (restart) within a few reference cycles.
- R3: An output starts toggling only once lock is reported, no sooner than RESTART_CYC (default 4) periods of its own clock after the lock rises and within 300 ns, and its first high pulse is a full half period; status then reads 1 (run).
- R4: A request that is low for only one reference-clock sample does not start power-down: status stays 1 and every output keeps toggling.
- R5: Two consecutive low samples start power-down (status 2, parking); every single-ended output stops low at a falling edge, with no high pulse shorter than its half period.
- R6: In power-down both legs of every differential pair are held low.
- R7: The oscillator and VCO enables fall only after every output has stopped; status then reads 3 (off).
- R8: Releasing the pin raises the oscillator and VCO enables and sets status 4; outputs stay low for as long as lock is absent.
- R9: If the pin goes low within WIN_CYC (default 1000) reference cycles after first power-good, the block reaches status 3 with the oscillator off and no output has ever toggled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; the sequencer runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pwrgd_pd_n_i | input | 1 | Shared power-good / active-low power-down pin, asynchronous |
| pll_lock_i | input | 1 | PLL lock indication, asynchronous |
| se_src_i | input | N_SE | Free-running source clocks of the single-ended outputs |
| dif_src_i | input | N_DIFF | Free-running source clocks of the differential outputs |
| se_clk_o | output | N_SE | Gated single-ended output clocks |
| dif_p_o | output | N_DIFF | Gated true legs of the differential outputs |
| dif_n_o | output | N_DIFF | Gated complement legs of the differential outputs |
| osc_en_o | output | 1 | Crystal oscillator enable |
| vco_en_o | output | 1 | Synthesizer VCO enable |
| status_o | output | 3 | Sequencer state: 0 wait, 1 run, 2 parking, 3 off, 4 restart |

## Verification
The bench drives a one-sample low pulse on the pin, which a design counting a single sample as entry would answer by parking the outputs. It watches every output leg for high pulses shorter than a half period, which a gate switching on the wrong edge or opening before its clock's low phase would produce, and it checks that no leg moves after the oscillator enable falls. It holds lock low after release to catch outputs that restart without lock, and it drops the pin early after first power-good, where a design ignoring the start-up window would briefly open the outputs before shutting down.

// File: rtl/clkpd_pkg.sv
`timescale 1ns/1ps
// Shared types of the clock output power-down sequencer.
package clkpd_pkg;
    // Sequencer states; the encoding is visible on status_o.
    typedef enum logic [2:0] {
        ST_WAIT    = 3'd0,
        ST_RUN     = 3'd1,
        ST_PARK    = 3'd2,
        ST_OFF     = 3'd3,
        ST_RESTART = 3'd4
    } pd_state_e;
endpackage

// File: rtl/clkpd_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a vector of independent asynchronous bits.
// Assumes each bit is a level that stays stable for several destination
// cycles; no coherence between bits is promised.
module clkpd_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
        end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/clkpd_gate.sv
`timescale 1ns/1ps
// Glitch-free gate for one output clock, clocked by that output's source.
// The run request from the sequencer is resynchronised here; after it has
// been high for RESTART_CYC source cycles the gate opens on a falling
// edge, and it closes on a falling edge as soon as the request drops.
// A differential gate closes its complement leg one rising edge later so
// neither leg ever shows a short pulse. idle_o reports that the gate and
// its request pipeline are fully shut. Assumes the source clock runs.
module clkpd_gate #(
    parameter bit IS_DIFF     = 1'b0,
    parameter int RESTART_CYC = 4
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic run_req_i,
    output logic out_p,
    output logic out_n,
    output logic busy_o,
    output logic idle_o
);
    localparam int CW = $clog2(RESTART_CYC + 1);

    logic          req_s;
    logic [CW-1:0] cnt_q;
    logic          ready;
    logic          en_p_q;
    logic          en_n;

    clkpd_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_req_sync (
        .clk   (clk_src),
        .rst_n (rst_n),
        .d_i   (run_req_i),
        .q_o   (req_s)
    );

    // Count source cycles since the request arrived, saturating.
    always_ff @(posedge clk_src) begin
        if (!rst_n || !req_s) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(RESTART_CYC)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign ready = req_s && (cnt_q == CW'(RESTART_CYC));

    // Open or close the true leg while the source is low.
    always_ff @(negedge clk_src) begin
        if (!rst_n) en_p_q <= 1'b0;
        else        en_p_q <= ready;
    end

    assign out_p = clk_src & en_p_q;

    generate
        if (IS_DIFF) begin : g_diff
            logic en_n_q;
            // Follow the true leg on the rising edge, when the complement is low.
            always_ff @(posedge clk_src) begin
                if (!rst_n) en_n_q <= 1'b0;
                else        en_n_q <= en_p_q;
            end
            assign en_n  = en_n_q;
            assign out_n = ~clk_src & en_n_q;
        end else begin : g_single
            assign en_n  = 1'b0;
            assign out_n = 1'b0;
        end
    endgenerate

    assign busy_o = en_p_q | en_n;
    assign idle_o = !busy_o && !req_s && !run_req_i;
endmodule

// File: rtl/clkpd_fsm.sv
`timescale 1ns/1ps
// Power sequencing state machine on the reference clock.
// Inputs pd_s, lock_s and idle_s are already synchronised. Entry into
// power-down needs two consecutive low samples of pd_s. During the first
// start-up the outputs are held off for WIN_CYC cycles so that an early
// power-down goes straight to OFF. After a request drops, PARK_HOLD cycles
// pass before the gates' idle flags are trusted.
module clkpd_fsm
    import clkpd_pkg::*;
#(
    parameter int NT        = 3,
    parameter int WIN_CYC   = 1000,
    parameter int PARK_HOLD = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pd_s,
    input  logic          lock_s,
    input  logic [NT-1:0] idle_s,
    output logic          run_req_o,
    output logic          osc_en_o,
    output pd_state_e     state_o
);
    localparam int WW = $clog2(WIN_CYC + 1);
    localparam int HW = $clog2(PARK_HOLD + 1);

    pd_state_e     state_q, state_d;
    logic          pd_q;
    logic          first_q;
    logic [WW-1:0] win_q;
    logic [HW-1:0] hold_q;
    logic          low2;
    logic          early;
    logic          run_q, osc_q;

    assign low2  = !pd_s && !pd_q;
    assign early = first_q && (win_q != WW'(WIN_CYC));

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:    if (pd_s) state_d = ST_RESTART;
            ST_RESTART: begin
                if (low2)                 state_d = early ? ST_OFF : ST_PARK;
                else if (lock_s && !early) state_d = ST_RUN;
            end
            ST_RUN:     if (low2) state_d = ST_PARK;
            ST_PARK:    if (hold_q == HW'(PARK_HOLD) && (&idle_s)) state_d = ST_OFF;
            ST_OFF:     if (pd_s) state_d = ST_RESTART;
            default:    state_d = ST_WAIT;
        endcase
    end

    // State, previous pin sample and registered enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            pd_q    <= 1'b0;
            run_q   <= 1'b0;
            osc_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            pd_q    <= pd_s;
            run_q   <= (state_d == ST_RUN);
            osc_q   <= (state_d != ST_OFF);
        end
    end

    // First start-up window counter and flag.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_WAIT) begin
            first_q <= 1'b1;
            win_q   <= '0;
        end else if (state_q != ST_RESTART) begin
            first_q <= 1'b0;
        end else if (win_q != WW'(WIN_CYC)) begin
            win_q <= win_q + WW'(1);
        end
    end

    // Dwell counter for the parking state.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != ST_PARK) hold_q <= '0;
        else if (hold_q != HW'(PARK_HOLD)) hold_q <= hold_q + HW'(1);
    end

    assign run_req_o = run_q;
    assign osc_en_o  = osc_q;
    assign state_o   = state_q;
endmodule

// File: rtl/clkpd_seq.sv
`timescale 1ns/1ps
// Clock output power-down sequencer, top level.
// Synchronises the shared power-good / power-down pin and the lock input,
// runs the sequencing state machine and instantiates one glitch-free gate
// per output clock. Assumes every source clock keeps running while the
// oscillator enable is low (the analog side is not modelled).
module clkpd_seq
    import clkpd_pkg::*;
#(
    parameter int N_SE        = 2,
    parameter int N_DIFF      = 1,
    parameter int WIN_CYC     = 1000,
    parameter int PARK_HOLD   = 16,
    parameter int RESTART_CYC = 4
) (
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic              pwrgd_pd_n_i,
    input  logic              pll_lock_i,
    input  logic [N_SE-1:0]   se_src_i,
    input  logic [N_DIFF-1:0] dif_src_i,
    output logic [N_SE-1:0]   se_clk_o,
    output logic [N_DIFF-1:0] dif_p_o,
    output logic [N_DIFF-1:0] dif_n_o,
    output logic              osc_en_o,
    output logic              vco_en_o,
    output logic [2:0]        status_o
);
    localparam int NT = N_SE + N_DIFF;

    logic          pd_s, lock_s;
    logic [NT-1:0] idle, idle_s;
    logic [NT-1:0] gate_busy;
    logic [NT-1:0] leg_p, leg_n;
    logic [NT-1:0] src_all;
    logic          run_req;
    logic          osc_en;
    pd_state_e     state;

    clkpd_sync #(.W(2), .STAGES(2), .RST_VAL(2'b00)) u_in_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d_i   ({pll_lock_i, pwrgd_pd_n_i}),
        .q_o   ({lock_s, pd_s})
    );

    clkpd_sync #(.W(NT), .STAGES(2), .RST_VAL({NT{1'b1}})) u_idle_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d_i   (idle),
        .q_o   (idle_s)
    );

    clkpd_fsm #(.NT(NT), .WIN_CYC(WIN_CYC), .PARK_HOLD(PARK_HOLD)) u_fsm (
        .clk       (ref_clk),
        .rst_n     (rst_n),
        .pd_s      (pd_s),
        .lock_s    (lock_s),
        .idle_s    (idle_s),
        .run_req_o (run_req),
        .osc_en_o  (osc_en),
        .state_o   (state)
    );

    assign src_all = {dif_src_i, se_src_i};

    generate
        for (genvar i = 0; i < NT; i++) begin : g_gate
            clkpd_gate #(.IS_DIFF(i >= N_SE), .RESTART_CYC(RESTART_CYC)) u_gate (
                .clk_src   (src_all[i]),
                .rst_n     (rst_n),
                .run_req_i (run_req),
                .out_p     (leg_p[i]),
                .out_n     (leg_n[i]),
                .busy_o    (gate_busy[i]),
                .idle_o    (idle[i])
            );
        end
    endgenerate

    assign se_clk_o = leg_p[N_SE-1:0];
    assign dif_p_o  = leg_p[NT-1:N_SE];
    assign dif_n_o  = leg_n[NT-1:N_SE];
    assign osc_en_o = osc_en;
    assign vco_en_o = osc_en;
    assign status_o = state;
endmodule

// File: rtl/clkpd_seq_chk.sv
`timescale 1ns/1ps
// Property checker for clkpd_seq, attached by bind. Observes the state,
// the enables, the gate activity and the output legs on the reference clock.
module clkpd_seq_chk #(
    parameter int NT = 3
) (
    input logic          ref_clk,
    input logic          rst_n,
    input logic [2:0]    status_o,
    input logic          osc_en_o,
    input logic          vco_en_o,
    input logic          lock_s,
    input logic [NT-1:0] gate_busy,
    input logic [NT-1:0] leg_p,
    input logic [NT-1:0] leg_n
);
    AST_STATUS_LEGAL: assert property (@(posedge ref_clk) disable iff (!rst_n)
        status_o <= 3'd4); // R1

    AST_WAIT_GATED: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (status_o == 3'd0) |-> (gate_busy == '0)); // R2

    AST_RUN_NEEDS_LOCK: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (status_o == 3'd1 && $past(status_o) == 3'd4) |-> $past(lock_s)); // R3

    AST_OFF_LEGS_LOW: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (status_o == 3'd3) |-> (leg_p == '0 && leg_n == '0)); // R6

    AST_OSC_OFF_PARKED: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(osc_en_o) |-> (gate_busy == '0)); // R7

    AST_OFF_ENTRY_PATH: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (status_o == 3'd3 && $past(status_o) != 3'd3) |->
            ($past(status_o) == 3'd2 || $past(status_o) == 3'd4)); // R9

    AST_RESTART_OSC_ON: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (status_o == 3'd4) |-> (osc_en_o && vco_en_o)); // R8
endmodule

bind clkpd_seq clkpd_seq_chk #(.NT(NT)) u_chk (
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .status_o  (status_o),
    .osc_en_o  (osc_en_o),
    .vco_en_o  (vco_en_o),
    .lock_s    (lock_s),
    .gate_busy (gate_busy),
    .leg_p     (leg_p),
    .leg_n     (leg_n)
);

// File: tb/sim_clkpd_seq.sv
`timescale 1ns/1ps
// Directed bench for clkpd_seq: one task per scenario.
module sim_clkpd_seq;
    logic       ref_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       pin     = 1'b0;
    logic       lock    = 1'b0;
    logic [1:0] se_src  = 2'b00;
    logic [0:0] dif_src = 1'b0;
    logic [1:0] se_o;
    logic [0:0] dp_o, dn_o;
    logic       osc_en, vco_en;
    logic [2:0] status;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  mark_id = 0;
    real osc_off_t = 0.0;

    clkpd_seq u0 (
        .ref_clk      (ref_clk),
        .rst_n        (rst_n),
        .pwrgd_pd_n_i (pin),
        .pll_lock_i   (lock),
        .se_src_i     (se_src),
        .dif_src_i    (dif_src),
        .se_clk_o     (se_o),
        .dif_p_o      (dp_o),
        .dif_n_o      (dn_o),
        .osc_en_o     (osc_en),
        .vco_en_o     (vco_en),
        .status_o     (status)
    );

    // 125 MHz reference and three free-running sources.
    always #4 ref_clk = ~ref_clk;
    always #5 se_src[0] = ~se_src[0];
    always #7 se_src[1] = ~se_src[1];
    always #6 dif_src[0] = ~dif_src[0];

    logic [3:0] legs;
    assign legs = {dn_o[0], dp_o[0], se_o[1], se_o[0]};

    // Per-leg activity monitor: edge count, first rise after a mark, runts.
    for (genvar k = 0; k < 4; k++) begin : g_mon
        localparam real HALF = (k == 0) ? 5.0 : (k == 1) ? 7.0 : 6.0;
        int  edges = 0;
        int  runts = 0;
        int  seen_id = 0;
        bit  had_rise = 1'b0;
        real rise_t = 0.0;
        real first_t = 0.0;
        always @(posedge legs[k]) begin
            edges++;
            rise_t = $realtime;
            had_rise = 1'b1;
            if (seen_id != mark_id) begin
                seen_id = mark_id;
                first_t = $realtime;
            end
        end
        always @(negedge legs[k]) begin
            if (had_rise && ($realtime - rise_t) < HALF - 0.5) runts++;
        end
    end

    always @(negedge osc_en) osc_off_t = $realtime;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic ref_cycles(input int n);
        repeat (n) @(posedge ref_clk);
        #2;
    endtask

    function automatic int total_edges();
        return g_mon[0].edges + g_mon[1].edges + g_mon[2].edges + g_mon[3].edges;
    endfunction

    function automatic int total_runts();
        return g_mon[0].runts + g_mon[1].runts + g_mon[2].runts + g_mon[3].runts;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        ref_cycles(20);
        rst_n = 1'b1;
        ref_cycles(2);
    endtask

    // R1: reset state.
    task automatic t_reset();
        pin = 1'b0; lock = 1'b0;
        do_reset();
        chk(status == 3'd0, "R1", "status after reset", status, 0);
        chk(legs == 4'b0, "R1", "legs after reset", legs, 0);
        chk(osc_en && vco_en, "R1", "osc/vco enables after reset", {osc_en, vco_en}, 3);
    endtask

    // R2: low pin while waiting is not a power-down; high pin starts up.
    task automatic t_wait_low();
        int e0 = total_edges();
        ref_cycles(50);
        chk(status == 3'd0, "R2", "status with pin low", status, 0);
        chk(total_edges() == e0, "R2", "edges while waiting", total_edges() - e0, 0);
        pin = 1'b1;
        ref_cycles(5);
        chk(status == 3'd4, "R2", "status after power-good", status, 4);
    endtask

    // R3: outputs start only after lock and the restart delay.
    task automatic t_startup();
        int  e0 = total_edges();
        int  r0 = total_runts();
        real t_lock;
        real per [4] = '{10.0, 14.0, 12.0, 12.0};
        ref_cycles(1100);
        chk(total_edges() == e0, "R3", "edges before lock", total_edges() - e0, 0);
        chk(status == 3'd4, "R3", "status before lock", status, 4);
        mark_id++;
        lock = 1'b1;
        t_lock = $realtime;
        #400;
        ref_cycles(1);
        for (int k = 0; k < 4; k++) begin
            real d;
            int  seen;
            case (k)
                0: begin d = g_mon[0].first_t - t_lock; seen = g_mon[0].seen_id; end
                1: begin d = g_mon[1].first_t - t_lock; seen = g_mon[1].seen_id; end
                2: begin d = g_mon[2].first_t - t_lock; seen = g_mon[2].seen_id; end
                default: begin d = g_mon[3].first_t - t_lock; seen = g_mon[3].seen_id; end
            endcase
            chk(seen == mark_id && d >= 4.0 * per[k] && d <= 300.0, "R3",
                $sformatf("leg %0d lock-to-first-rise ns", k), longint'(d), longint'(4.0 * per[k]));
        end
        chk(status == 3'd1, "R3", "status after lock", status, 1);
        chk(total_runts() == r0, "R3", "runts at start", total_runts() - r0, 0);
    endtask

    // R4: a single low sample does not enter power-down.
    task automatic t_cancel();
        int e0;
        @(negedge ref_clk);
        pin = 1'b0;
        @(negedge ref_clk);
        pin = 1'b1;
        e0 = total_edges();
        ref_cycles(40);
        chk(status == 3'd1, "R4", "status after short pulse", status, 1);
        chk(total_edges() - e0 > 40, "R4", "edges after short pulse", total_edges() - e0, 41);
    endtask

    // R5, R6, R7: orderly power-down.
    task automatic t_pdown();
        int  r0 = total_runts();
        bit  saw_park = 1'b0;
        real last_rise;
        pin = 1'b0;
        for (int i = 0; i < 100; i++) begin
            ref_cycles(1);
            if (status == 3'd2) saw_park = 1'b1;
        end
        chk(saw_park, "R5", "parking state seen", saw_park, 1);
        chk(total_runts() == r0, "R5", "runts while parking", total_runts() - r0, 0);
        chk(se_o == 2'b00, "R5", "single-ended legs parked", se_o, 0);
        chk(dp_o == 1'b0 && dn_o == 1'b0, "R6", "differential legs parked", {dp_o, dn_o}, 0);
        chk(status == 3'd3, "R7", "status after power-down", status, 3);
        chk(!osc_en && !vco_en, "R7", "osc/vco off", {osc_en, vco_en}, 0);
        last_rise = g_mon[0].rise_t;
        if (g_mon[1].rise_t > last_rise) last_rise = g_mon[1].rise_t;
        if (g_mon[2].rise_t > last_rise) last_rise = g_mon[2].rise_t;
        if (g_mon[3].rise_t > last_rise) last_rise = g_mon[3].rise_t;
        chk(last_rise < osc_off_t, "R7", "last leg rise before osc off (ns)",
            longint'(last_rise), longint'(osc_off_t));
    endtask

    // R8: release restores osc/vco, outputs wait for lock.
    task automatic t_release();
        int e0 = total_edges();
        lock = 1'b0;
        ref_cycles(10);
        pin = 1'b1;
        ref_cycles(6);
        chk(osc_en && vco_en, "R8", "osc/vco on after release", {osc_en, vco_en}, 3);
        chk(status == 3'd4, "R8", "status after release", status, 4);
        ref_cycles(200);
        chk(total_edges() == e0, "R8", "edges without lock", total_edges() - e0, 0);
        lock = 1'b1;
        ref_cycles(60);
        chk(status == 3'd1 && total_edges() > e0, "R8", "running after lock", status, 1);
    endtask

    // R9: early power-down after first power-good never opens outputs.
    task automatic t_early();
        int e0;
        pin = 1'b0; lock = 1'b1;
        do_reset();
        e0 = total_edges();
        pin = 1'b1;
        ref_cycles(20);
        pin = 1'b0;
        ref_cycles(100);
        chk(status == 3'd3, "R9", "status after early power-down", status, 3);
        chk(!osc_en, "R9", "osc off after early power-down", osc_en, 0);
        chk(total_edges() == e0, "R9", "edges during early power-down", total_edges() - e0, 0);
        pin = 1'b1;
        ref_cycles(100);
        chk(status == 3'd1 && total_edges() > e0, "R9", "runs after later release", status, 1);
    endtask

    initial begin
        t_reset();
        t_wait_low();
        t_startup();
        t_cancel();
        t_pdown();
        t_release();
        t_early();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule